// File: doc/BRIEF.md
# Sprite Attribute Table Access Port

This block is the processor-facing window into a sprite attribute store. The store has two parts: a 512-byte main table, kept as 256 byte pairs, and a 32-byte auxiliary table. Software sets a word base address through two address-byte writes. It then streams data bytes in or out through a single data register. Every data access advances a 10-bit byte pointer by one. When pointer bit 9 is clear, the access goes to the main table. When it is set, the access goes to the auxiliary table.

Writes to the main table land only as complete byte pairs. A byte written at an even pointer waits in a holding register. The following byte, at the odd pointer, commits both bytes to storage together. Writes to the auxiliary table go straight to storage, one byte at a time. The block also produces a rotating first-sprite index for the sprite evaluator. When the display is blanked and the line counter arrives at the vertical-blank line, the block reloads the pointer from the base address.

Top module: `obj_attr_port`

## Requirements
- R1: A write with `wr_sel`=0 replaces base address bits 7:0 with `wr_data`. In the same cycle it reloads the pointer with the 9-bit base shifted left one place (`ptr_o` = base×2, so bit 0 is 0).
- R2: A write with `wr_sel`=1 takes the rotation flag from `wr_data` bit 7 and base bit 8 from `wr_data` bit 0. It reloads the pointer the same way as R1.
- R3: A data write (`wr_sel`=2) at an even pointer in the main table only captures the byte in the holding register. Stored contents do not change.
- R4: A data write at an odd pointer in the main table stores the held byte at the even address and the new byte at the odd address, in one cycle.
- R5: When pointer bit 9 is 1, each data write is stored directly at auxiliary index pointer[4:0]. Pointer bits 8:5 are ignored, so the auxiliary table repeats every 32 bytes.
- R6: Every data write or data read raises the pointer by one, modulo 1024.
- R7: `first_idx` is 0 while the rotation flag is 0. While the flag is 1, `first_idx` equals pointer bits 8:2.
- R8: The pointer reloads from base×2 in one case only: `blank` is 1 and `line_cnt` changes to the vertical-blank line. That line is 225 when `tall`=0 and 240 when `tall`=1. The reload happens once per arrival, and never while `blank` is 0.
- R9: A data read (`rd_en`) returns the stored byte at the current pointer on `rd_data` one cycle later. The holding register is bypassed.
- R10: Synchronous reset clears the pointer, the base, the holding register, the rotation flag and `rd_data`.
- R11: A data access in the same cycle as a vertical-blank reload wins, and the reload is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 address low, 1 address high, 2 data, 3 none |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | 8 | Byte returned by the last data read |
| blank | input | 1 | Display blanked |
| tall | input | 1 | Selects the 240-line vertical-blank position |
| line_cnt | input | 9 | Current video line |
| ptr_o | output | 10 | Current byte pointer |
| first_idx | output | 7 | First-sprite index for priority rotation |

## Verification
The assertions check the pointer's cycle-by-cycle rules on every cycle. These are:
- the reload after an address write;
- the single-step advance on each data access;
- the pointer holding still while idle with the display active;
- the index being forced to zero, or tracking the pointer.

What was actually stored is not visible to properties on the ports. That covers pair-only commits, held bytes being bypassed on reads, and auxiliary-table aliasing, and only bench scenarios that read memory back can show it. The bench scenarios also cover reload at the right line for each height setting, the single reload per arrival, and access winning over a reload.

// File: rtl/obj_attr_pkg.sv
package obj_attr_pkg;

   typedef enum logic [1:0] {
      SEL_ADDR_LO = 2'd0,
      SEL_ADDR_HI = 2'd1,
      SEL_DATA    = 2'd2,
      SEL_NONE    = 2'd3
   } port_sel_e;

endpackage

// File: rtl/obj_ptr_ctrl.sv
module obj_ptr_ctrl #(
   parameter int PTR_W        = 10,
   parameter int LINE_W       = 9,
   parameter int VB_LINE      = 225,
   parameter int VB_LINE_TALL = 240
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              addr_lo_we,
   input  logic              addr_hi_we,
   input  logic [7:0]        wdata,
   input  logic              step,
   input  logic              blank,
   input  logic              tall,
   input  logic [LINE_W-1:0] line_cnt,
   output logic [PTR_W-1:0]  ptr,
   output logic [PTR_W-4:0]  first_idx
);
   localparam int BASE_W = PTR_W - 1;
   localparam int HI_W   = BASE_W - 8;
   localparam logic [LINE_W-1:0] TGT_STD  = LINE_W'(VB_LINE);
   localparam logic [LINE_W-1:0] TGT_TALL = LINE_W'(VB_LINE_TALL);

   logic [BASE_W-1:0] base_q, base_nxt;
   logic              prio_q;
   logic [PTR_W-1:0]  ptr_q;
   logic [LINE_W-1:0] line_q;
   logic [LINE_W-1:0] tgt;
   logic              vb_hit;

   // Next base value for either address-byte write
   always_comb begin
      base_nxt = base_q;
      if (addr_lo_we)
         base_nxt = {base_q[BASE_W-1:8], wdata};
      else if (addr_hi_we)
         base_nxt = {wdata[HI_W-1:0], base_q[7:0]};
   end

   // Vertical-blank reload fires once, on arrival at the target line
   assign tgt    = tall ? TGT_TALL : TGT_STD;
   assign vb_hit = blank && (line_cnt == tgt) && (line_q != tgt);

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         prio_q <= 1'b0;
         ptr_q  <= '0;
         line_q <= '0;
      end else begin
         line_q <= line_cnt;
         base_q <= base_nxt;
         if (addr_hi_we)
            prio_q <= wdata[7];
         if (addr_lo_we || addr_hi_we)
            ptr_q <= {base_nxt, 1'b0};
         else if (step)
            ptr_q <= ptr_q + 1'b1;
         else if (vb_hit)
            ptr_q <= {base_q, 1'b0};
      end
   end

   assign ptr       = ptr_q;
   assign first_idx = prio_q ? ptr_q[PTR_W-2:2] : '0;

endmodule

// File: rtl/obj_pair_latch.sv
module obj_pair_latch #(
   parameter int PTR_W = 10,
   parameter int HI_IW = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             data_we,
   input  logic [PTR_W-1:0] ptr,
   input  logic [7:0]       wdata,
   output logic             lo_we,
   output logic [PTR_W-3:0] lo_idx,
   output logic [15:0]      lo_word,
   output logic             hi_we,
   output logic [HI_IW-1:0] hi_idx,
   output logic [7:0]       hi_byte
);
   logic [7:0] hold_q;
   logic       in_high;

   assign in_high = ptr[PTR_W-1];

   // Even-pointer writes only refresh the holding byte
   always_ff @(posedge clk) begin
      if (rst)
         hold_q <= '0;
      else if (data_we && !ptr[0])
         hold_q <= wdata;
   end

   assign lo_we   = data_we && !in_high && ptr[0];
   assign lo_idx  = ptr[PTR_W-2:1];
   assign lo_word = {wdata, hold_q};
   assign hi_we   = data_we && in_high;
   assign hi_idx  = ptr[HI_IW-1:0];
   assign hi_byte = wdata;

endmodule

// File: rtl/obj_attr_mem.sv
module obj_attr_mem #(
   parameter int PTR_W      = 10,
   parameter int HIGH_BYTES = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             lo_we,
   input  logic [PTR_W-3:0] lo_idx,
   input  logic [15:0]      lo_word,
   input  logic             hi_we,
   input  logic [$clog2(HIGH_BYTES)-1:0] hi_idx,
   input  logic [7:0]       hi_byte,
   input  logic             rd_en,
   input  logic [PTR_W-1:0] rd_ptr,
   output logic [7:0]       rd_data
);
   localparam int LO_WORDS = 1 << (PTR_W - 2);
   localparam int HI_IW    = $clog2(HIGH_BYTES);

   logic [7:0] lane_rd [2];
   logic [7:0] hi_tab [HIGH_BYTES];

   // One byte lane per half of each pair, written together
   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [7:0] lane [LO_WORDS];
      always_ff @(posedge clk) begin
         if (lo_we)
            lane[lo_idx] <= lo_word[8*g +: 8];
      end
      assign lane_rd[g] = lane[rd_ptr[PTR_W-2:1]];
   end

   always_ff @(posedge clk) begin
      if (hi_we)
         hi_tab[hi_idx] <= hi_byte;
   end

   always_ff @(posedge clk) begin
      if (rst)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= rd_ptr[PTR_W-1] ? hi_tab[rd_ptr[HI_IW-1:0]]
                                    : lane_rd[rd_ptr[0]];
   end

endmodule

// File: rtl/obj_attr_port.sv
module obj_attr_port
   import obj_attr_pkg::*;
#(
   parameter int LOW_BYTES    = 512,
   parameter int HIGH_BYTES   = 32,
   parameter int LINE_W       = 9,
   parameter int VB_LINE      = 225,
   parameter int VB_LINE_TALL = 240
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   output logic [7:0]        rd_data,
   input  logic              blank,
   input  logic              tall,
   input  logic [LINE_W-1:0] line_cnt,
   output logic [$clog2(LOW_BYTES):0]   ptr_o,
   output logic [$clog2(LOW_BYTES)-3:0] first_idx
);
   localparam int PTR_W = $clog2(LOW_BYTES) + 1;
   localparam int HI_IW = $clog2(HIGH_BYTES);

   initial begin
      if ((1 << (PTR_W - 1)) != LOW_BYTES)
         $error("LOW_BYTES must be a power of two");
      if (PTR_W < 10)
         $error("LOW_BYTES must be at least 512");
      if ((1 << HI_IW) != HIGH_BYTES || HIGH_BYTES > LOW_BYTES)
         $error("HIGH_BYTES must be a power of two no larger than LOW_BYTES");
      if (VB_LINE >= (1 << LINE_W) || VB_LINE_TALL >= (1 << LINE_W))
         $error("blank lines must fit in LINE_W");
   end

   logic             sel_lo, sel_hi, sel_data, step;
   logic             lo_we, hi_we;
   logic [PTR_W-3:0] lo_idx;
   logic [15:0]      lo_word;
   logic [HI_IW-1:0] hi_idx;
   logic [7:0]       hi_byte;

   assign sel_lo   = wr_en && (wr_sel == SEL_ADDR_LO);
   assign sel_hi   = wr_en && (wr_sel == SEL_ADDR_HI);
   assign sel_data = wr_en && (wr_sel == SEL_DATA);
   assign step     = sel_data || rd_en;

   obj_ptr_ctrl #(
      .PTR_W(PTR_W), .LINE_W(LINE_W),
      .VB_LINE(VB_LINE), .VB_LINE_TALL(VB_LINE_TALL)
   ) ptr_i (
      .clk(clk), .rst(rst),
      .addr_lo_we(sel_lo), .addr_hi_we(sel_hi), .wdata(wr_data),
      .step(step), .blank(blank), .tall(tall), .line_cnt(line_cnt),
      .ptr(ptr_o), .first_idx(first_idx)
   );

   obj_pair_latch #(.PTR_W(PTR_W), .HI_IW(HI_IW)) pair_i (
      .clk(clk), .rst(rst), .data_we(sel_data), .ptr(ptr_o), .wdata(wr_data),
      .lo_we(lo_we), .lo_idx(lo_idx), .lo_word(lo_word),
      .hi_we(hi_we), .hi_idx(hi_idx), .hi_byte(hi_byte)
   );

   obj_attr_mem #(.PTR_W(PTR_W), .HIGH_BYTES(HIGH_BYTES)) mem_i (
      .clk(clk), .rst(rst),
      .lo_we(lo_we), .lo_idx(lo_idx), .lo_word(lo_word),
      .hi_we(hi_we), .hi_idx(hi_idx), .hi_byte(hi_byte),
      .rd_en(rd_en && !sel_data), .rd_ptr(ptr_o), .rd_data(rd_data)
   );

endmodule

// File: rtl/obj_attr_port_chk.sv
module obj_attr_port_chk #(
   parameter int LOW_BYTES = 512
) (
   input logic                          clk,
   input logic                          rst,
   input logic                          wr_en,
   input logic [1:0]                    wr_sel,
   input logic [7:0]                    wr_data,
   input logic                          rd_en,
   input logic                          blank,
   input logic [$clog2(LOW_BYTES):0]    ptr_o,
   input logic [$clog2(LOW_BYTES)-3:0]  first_idx
);
   localparam int PW = $clog2(LOW_BYTES) + 1;

   assert_lo_reload_R1: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == 2'd0) |=> (ptr_o[0] == 1'b0 && ptr_o[8:1] == $past(wr_data)));

   assert_hi_reload_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == 2'd1) |=> (ptr_o[0] == 1'b0 && ptr_o[PW-1] == $past(wr_data[0])));

   assert_step_R6: assert property (@(posedge clk) disable iff (rst)
      ((wr_en && wr_sel == 2'd2) || (rd_en && !wr_en)) |=> (ptr_o == $past(ptr_o) + 1'b1));

   assert_flag_off_R7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == 2'd1 && !wr_data[7]) |=> (first_idx == '0));

   assert_idx_track_R7: assert property (@(posedge clk) disable iff (rst)
      (first_idx != '0) |-> (first_idx == ptr_o[PW-2:2]));

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !rd_en && !blank) |=> $stable(ptr_o));

endmodule

bind obj_attr_port obj_attr_port_chk chk_i (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .rd_en(rd_en), .blank(blank), .ptr_o(ptr_o), .first_idx(first_idx)
);

// File: tb/obj_attr_port_tb_top.sv
`timescale 1ns/1ps
module obj_attr_port_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd3;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       blank = 1'b0;
   logic       tall = 1'b0;
   logic [8:0] line_cnt = '0;
   logic [9:0] ptr_o;
   logic [6:0] first_idx;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   obj_attr_port dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .blank(blank), .tall(tall),
      .line_cnt(line_cnt), .ptr_o(ptr_o), .first_idx(first_idx)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3;
   endtask

   task automatic do_rd(output logic [7:0] v);
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   task automatic set_base(input logic [8:0] b, input logic flag);
      do_wr(2'd0, b[7:0]);
      do_wr(2'd1, {flag, 6'd0, b[8]});
   endtask

   task automatic set_line(input logic [8:0] l);
      @(negedge clk);
      line_cnt = l;
      @(negedge clk);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R10 ptr after reset", ptr_o, 0);
      check("R10 index after reset", first_idx, 0);
      check("R10 rd_data after reset", rd_data, 0);
   endtask

   task automatic t_address;
      do_wr(2'd0, 8'h34);
      check("R1 low address reload", ptr_o, 10'h068);
      do_wr(2'd1, 8'h81);
      check("R2 high address reload", ptr_o, 10'h268);
      check("R7 rotation index", first_idx, 7'h1A);
      do_wr(2'd1, 8'h01);
      check("R7 index zero with flag off", first_idx, 0);
      check("R2 pointer kept base", ptr_o, 10'h268);
   endtask

   task automatic t_pairs;
      logic [7:0] v;
      set_base(9'h010, 1'b0);
      do_wr(2'd2, 8'h11);
      do_wr(2'd2, 8'h22);
      set_base(9'h010, 1'b0);
      do_wr(2'd2, 8'hAA);
      set_base(9'h010, 1'b0);
      do_rd(v); check("R3 even write left memory", v, 8'h11);
      do_rd(v); check("R9 odd byte read", v, 8'h22);
      set_base(9'h010, 1'b0);
      do_wr(2'd2, 8'hAA);
      do_wr(2'd2, 8'hBB);
      set_base(9'h010, 1'b0);
      do_rd(v); check("R4 pair even byte", v, 8'hAA);
      do_rd(v); check("R4 pair odd byte", v, 8'hBB);
      set_base(9'h010, 1'b0);
      do_wr(2'd2, 8'hCC);
      do_rd(v); check("R9 read bypasses holding byte", v, 8'hBB);
   endtask

   task automatic t_high;
      logic [7:0] v;
      set_base(9'h100, 1'b0);
      check("R5 pointer in high table", ptr_o, 10'h200);
      do_wr(2'd2, 8'h5A);
      do_wr(2'd2, 8'h6B);
      set_base(9'h100, 1'b0);
      do_rd(v); check("R5 direct byte 0", v, 8'h5A);
      do_rd(v); check("R5 direct byte 1", v, 8'h6B);
      set_base(9'h110, 1'b0);
      do_rd(v); check("R5 alias of index 0", v, 8'h5A);
   endtask

   task automatic t_wrap;
      logic [7:0] v;
      set_base(9'h1FF, 1'b0);
      check("R6 start near top", ptr_o, 10'h3FE);
      do_rd(v);
      check("R6 step", ptr_o, 10'h3FF);
      do_rd(v);
      check("R6 wrap to zero", ptr_o, 10'h000);
   endtask

   task automatic t_index;
      logic [7:0] v;
      set_base(9'h044, 1'b1);
      check("R7 index from pointer", first_idx, 7'h22);
      do_rd(v);
      check("R7 index unchanged within group", first_idx, 7'h22);
      repeat (3) do_rd(v);
      check("R7 index follows pointer", first_idx, 7'h23);
      do_wr(2'd1, 8'h00);
   endtask

   task automatic t_reload;
      logic [7:0] v;
      set_base(9'h010, 1'b0);
      do_rd(v); do_rd(v);
      blank = 1'b1; tall = 1'b0;
      set_line(9'd224);
      check("R8 no reload off target", ptr_o, 10'h022);
      set_line(9'd225);
      check("R8 reload at line 225", ptr_o, 10'h020);
      do_rd(v);
      repeat (3) @(negedge clk);
      check("R8 reload once per arrival", ptr_o, 10'h021);
      blank = 1'b0;
      set_line(9'd0);
      set_line(9'd225);
      check("R8 no reload while shown", ptr_o, 10'h021);
      blank = 1'b1; tall = 1'b1;
      set_line(9'd0);
      set_line(9'd225);
      check("R8 tall ignores 225", ptr_o, 10'h021);
      set_line(9'd240);
      check("R8 tall reload at 240", ptr_o, 10'h020);
      set_line(9'd0);
      do_rd(v);
      @(negedge clk);
      line_cnt = 9'd240; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check("R11 access beats reload", ptr_o, 10'h022);
      blank = 1'b0; tall = 1'b0; line_cnt = '0;
   endtask

   task automatic t_reset_latch;
      logic [7:0] v;
      set_base(9'h018, 1'b0);
      do_wr(2'd2, 8'h77);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      set_base(9'h018, 1'b0);
      do_rd(v);
      do_wr(2'd2, 8'h99);
      set_base(9'h018, 1'b0);
      do_rd(v); check("R10 holding byte cleared", v, 8'h00);
      do_rd(v); check("R4 odd byte after reset", v, 8'h99);
   endtask

   initial begin
      #(200000 * 8);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_address();
      t_pairs();
      t_high();
      t_wrap();
      t_index();
      t_reload();
      t_reset_latch();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule